// File: doc/BRIEF.md
# Two-Phase Interrupt Pad Latch

This block captures three asynchronous pad levels (a non-maskable interrupt request, a maskable interrupt request and a reset request) under a two-phase, non-overlapping clock. The design runs on one fast system clock. Two single-cycle enable strobes, `phi1_en` and `phi2_en`, mark the two phases. Each pad feeds a level latch. That latch updates only in a cycle where the phi2 strobe is high, and it keeps its value in every other cycle. The core logic uses no edge detection.

The non-maskable channel is one cross-coupled NOR-of-AND pair. Its internal node holds the inverse of the sampled pad level, and its line shows the true level. The maskable and reset channels add a transfer stage gated by phi1 and a static output latch after it. On each phi1 strobe this output latch takes the inverse of the input latch, so these two lines lag their input latches by one phase. A cycle where both strobes are high is illegal. In such a cycle every latch keeps its value, and an error flag is raised for the next cycle.

Top module: `ipl_pad_latch`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all three lines read 1 (inactive) and `phase_err` reads 0.
- R2: In a cycle with `phi2_en`=1 and `phi1_en`=0, the clock edge sets `nmi_line` to the level of `nmi_pad`, as seen from the next cycle. The internal node is set to the inverse of the pad level.
- R3: After any edge with `phi2_en`=0, `nmi_line` is unchanged, whatever `nmi_pad` does.
- R4: In a cycle with `phi2_en`=1 and `phi1_en`=0, the input latches of the maskable and reset channels take their pad levels. In other cycles they hold. An input latch is observed only through R5.
- R5: In a cycle with `phi1_en`=1 and `phi2_en`=0, the clock edge sets `irq_line` and `res_line` to the inverse of their input latch values as they stood before that edge. In every other cycle these lines hold.
- R6: If `phi1_en` and `phi2_en` are both 1 in a cycle, no latch changes at that edge, and `phase_err` reads 1 in the following cycle.
- R7: `phase_err` reads 0 after any edge taken without both strobes high.
- R8: The maskable and reset channels behave the same and separately: each one follows only its own pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phi1_en | input | 1 | Phase-1 strobe |
| phi2_en | input | 1 | Phase-2 strobe |
| nmi_pad | input | 1 | Non-maskable request pad level |
| irq_pad | input | 1 | Maskable request pad level |
| res_pad | input | 1 | Reset request pad level |
| nmi_line | output | 1 | Non-maskable internal line |
| irq_line | output | 1 | Maskable internal line (phase-delayed) |
| res_line | output | 1 | Reset internal line (phase-delayed) |
| phase_err | output | 1 | Both strobes were seen high in the previous cycle |

## Verification
Random strobe sequences with random pad levels cover every combination of held latch value, pad level and strobe, and each cycle is compared with a bench model of the transition tables. Directed runs toggle a pad several times between phi2 strobes, which shows whether the latch is transparent outside its phase. They also place phi1 between phi2 strobes, which separates the one-phase output lag from a direct path. Pads are driven in opposite directions so that crossed channels show up, and forced strobe overlaps show whether state is held and the flag is raised.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
   typedef struct packed {
      logic ph1;
      logic ph2;
   } ipl_phase_t;

   localparam int unsigned IPL_NUM_DLY = 2;
   localparam logic        IPL_LINE_IDLE = 1'b1;
endpackage

// File: rtl/ipl_phase_guard.sv
module ipl_phase_guard
   import ipl_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       phi1_en,
   input  logic       phi2_en,
   output ipl_phase_t ph_g,
   output logic       err_q
);
   logic clash;
   assign clash   = phi1_en & phi2_en;
   assign ph_g.ph1 = phi1_en & ~clash;
   assign ph_g.ph2 = phi2_en & ~clash;

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= clash;
   end

   // R6
   clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (phi1_en && phi2_en) |=> err_q);
   // R7
   clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
      !(phi1_en && phi2_en) |=> !err_q);
endmodule

// File: rtl/ipl_nor_latch.sv
module ipl_nor_latch
   import ipl_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ph2,
   input  logic pad,
   output logic line
);
   logic lat_q, side_b, lat_d;

   // cross-coupled NOR of AND terms, evaluated once per system clock
   assign side_b = ~((~pad & ph2) | lat_q);
   assign lat_d  = ~((pad & ph2) | side_b);

   always_ff @(posedge clk) begin
      if (rst) lat_q <= ~IPL_LINE_IDLE;
      else     lat_q <= lat_d;
   end

   assign line = ~lat_q;

   // R2
   nmi_load_chk: assert property (@(posedge clk) disable iff (rst)
      ph2 |=> (line == $past(pad)));
   // R3
   nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ph2 |=> $stable(line));
endmodule

// File: rtl/ipl_dly_chan.sv
module ipl_dly_chan
   import ipl_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  ipl_phase_t ph,
   input  logic       pad,
   output logic       line
);
   logic in_q, out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_q  <= ~IPL_LINE_IDLE;
         out_q <= IPL_LINE_IDLE;
      end else begin
         if (ph.ph2) in_q  <= pad;
         if (ph.ph1) out_q <= ~in_q;
      end
   end

   assign line = out_q;

   // R4
   in_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ph.ph2 |=> $stable(in_q));
   // R5
   xfer_chk: assert property (@(posedge clk) disable iff (rst)
      ph.ph1 |=> (line == !$past(in_q)));
   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ph.ph1 |=> $stable(line));
endmodule

// File: rtl/ipl_pad_latch.sv
module ipl_pad_latch
   import ipl_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic phi1_en,
   input  logic phi2_en,
   input  logic nmi_pad,
   input  logic irq_pad,
   input  logic res_pad,
   output logic nmi_line,
   output logic irq_line,
   output logic res_line,
   output logic phase_err
);
   localparam int unsigned NDLY = IPL_NUM_DLY;

   if (NDLY != 2) begin : g_bad_cfg
      $error("ipl_pad_latch expects exactly two delayed channels");
   end

   ipl_phase_t ph_g;
   logic [NDLY-1:0] dly_pad, dly_line;

   assign dly_pad = {res_pad, irq_pad};

   ipl_phase_guard u_guard (
      .clk(clk), .rst(rst), .phi1_en(phi1_en), .phi2_en(phi2_en),
      .ph_g(ph_g), .err_q(phase_err)
   );

   ipl_nor_latch u_nmi (
      .clk(clk), .rst(rst), .ph2(ph_g.ph2), .pad(nmi_pad), .line(nmi_line)
   );

   for (genvar k = 0; k < NDLY; k++) begin : g_dly
      ipl_dly_chan u_ch (
         .clk(clk), .rst(rst), .ph(ph_g), .pad(dly_pad[k]), .line(dly_line[k])
      );
   end

   assign irq_line = dly_line[0];
   assign res_line = dly_line[1];

   // R6
   clash_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (phi1_en && phi2_en) |=> ($stable(nmi_line) && $stable(irq_line) && $stable(res_line)));
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (nmi_line && irq_line && res_line && !phase_err));
endmodule

// File: tb/ipl_pad_latch_tb.sv
module ipl_pad_latch_tb_top;
   localparam time CLK_PER = 10ns;
   localparam int  WDOG_CYC = 150000;

   logic clk = 1'b0, rst = 1'b1;
   logic phi1_en = 0, phi2_en = 0, nmi_pad = 0, irq_pad = 0, res_pad = 0;
   logic nmi_line, irq_line, res_line, phase_err;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model state
   logic m_nmi, m_irq_in, m_irq_out, m_res_in, m_res_out, m_err;

   always #(CLK_PER/2) clk = ~clk;

   ipl_pad_latch dut_i (
      .clk(clk), .rst(rst), .phi1_en(phi1_en), .phi2_en(phi2_en),
      .nmi_pad(nmi_pad), .irq_pad(irq_pad), .res_pad(res_pad),
      .nmi_line(nmi_line), .irq_line(irq_line), .res_line(res_line),
      .phase_err(phase_err)
   );

   function automatic logic nxt_in(logic held, logic pad, logic strobe);
      return strobe ? pad : held;
   endfunction

   function automatic logic nxt_out(logic held, logic in_old, logic strobe);
      return strobe ? ~in_old : held;
   endfunction

   task automatic chk(string req, string nm, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_nmi = 1; m_irq_in = 0; m_irq_out = 1; m_res_in = 0; m_res_out = 1; m_err = 0;
   endtask

   task automatic model_edge();
      logic clash, g1, g2, oi, orr;
      clash = phi1_en & phi2_en;
      g1 = phi1_en & ~clash;
      g2 = phi2_en & ~clash;
      oi = m_irq_in; orr = m_res_in;
      m_err     = clash;
      m_nmi     = g2 ? nmi_pad : m_nmi;
      m_irq_in  = nxt_in(m_irq_in, irq_pad, g2);
      m_res_in  = nxt_in(m_res_in, res_pad, g2);
      m_irq_out = nxt_out(m_irq_out, oi, g1);
      m_res_out = nxt_out(m_res_out, orr, g1);
   endtask

   task automatic compare_all(string ctx);
      string rq_n, rq_d;
      rq_n = (ctx == "clash") ? "R6" : "R2/R3";
      rq_d = (ctx == "clash") ? "R6" : "R5/R8";
      chk(rq_n, "nmi_line", nmi_line, m_nmi);
      chk(rq_d, "irq_line", irq_line, m_irq_out);
      chk(rq_d, "res_line", res_line, m_res_out);
      chk(m_err ? "R6" : "R7", "phase_err", phase_err, m_err);
   endtask

   // drive at negedge, let one edge pass, compare at the next negedge
   task automatic step(logic p1, logic p2, logic n, logic i, logic r);
      phi1_en = p1; phi2_en = p2; nmi_pad = n; irq_pad = i; res_pad = r;
      @(posedge clk);
      #1;
      model_edge();
      @(negedge clk);
      compare_all((p1 & p2) ? "clash" : "norm");
   endtask

   initial begin
      #(CLK_PER * WDOG_CYC);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1f3a_5c07));
      model_reset();
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "nmi_line", nmi_line, 1'b1);
      chk("R1", "irq_line", irq_line, 1'b1);
      chk("R1", "res_line", res_line, 1'b1);
      chk("R1", "phase_err", phase_err, 1'b0);
      rst = 0;

      // R2: nmi follows pad on phi2
      step(0, 1, 1, 0, 0);
      chk("R2", "nmi high after phi2", nmi_line, 1'b1);
      step(0, 1, 0, 0, 0);
      chk("R2", "nmi low after phi2", nmi_line, 1'b0);
      // R3: pad toggles without phi2 do nothing
      for (int k = 0; k < 4; k++) step(k[0], 0, ~k[0], 0, 0);
      chk("R3", "nmi held", nmi_line, 1'b0);

      // R4/R5/R8: opposite pads, capture then transfer
      step(0, 1, 0, 1, 0);
      chk("R5", "irq no change before phi1", irq_line, 1'b1);
      step(0, 0, 0, 0, 1);   // R4: pads change with no strobe
      step(1, 0, 0, 0, 1);
      chk("R4", "irq held capture inverted", irq_line, 1'b0);
      chk("R8", "res separate channel", res_line, 1'b1);
      step(0, 1, 0, 0, 1);
      step(1, 0, 0, 1, 0);
      chk("R5", "irq after second phi1", irq_line, 1'b1);
      chk("R8", "res after second phi1", res_line, 1'b0);

      // R6: overlap holds state and flags
      step(1, 1, 1, 1, 1);
      chk("R6", "flag set", phase_err, 1'b1);
      chk("R6", "res frozen", res_line, 1'b0);
      step(0, 0, 1, 1, 1);
      chk("R7", "flag clear", phase_err, 1'b0);

      // random mix
      for (int k = 0; k < 3000; k++) begin
         int unsigned sel;
         logic p1, p2;
         sel = $urandom_range(0, 15);
         p1 = (sel < 5) || (sel == 15);
         p2 = ((sel >= 5) && (sel < 10)) || (sel == 15);
         step(p1, p2, 1'($urandom), 1'($urandom), 1'($urandom));
      end

      // R1: reset mid-run
      rst = 1;
      @(posedge clk);
      model_reset();
      @(negedge clk);
      rst = 0;
      compare_all("norm");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule